// File: doc/BRIEF.md
# Two-Wire Dual-Channel DAC Register Slave

This block is the digital front end of a pair of 8-bit converter channels. It is a write-only slave on a two-wire serial bus. SCL and SDA are oversampled by the system clock. The block finds START and STOP conditions, compares the first byte with its own 7-bit address, and acknowledges each byte it accepts. After the address come one or more command bytes, each optionally followed by a data byte.

Each channel holds its code in two stages. Bus writes land in an input latch. Both output latches, which drive the converters, are reloaded together when STOP is seen. The power-down and clear commands are also held until STOP. A host can therefore change both channels, or change a code and power down, as one atomic step.

Top module: `dual_dac_i2c_slave`

## Requirements
- R1: The slave address is {0,1,0,M1,M0,P1,P0}, where P1/P0 are `addr_pin_i[1:0]`. M1/M0 are `addr_pin_i[3:2]` when `USE_ADDR_PINS`=1, and fixed at 1,1 otherwise. The eighth (LSB) bit of the first byte must be 0 (write). A matching address byte is acknowledged.
- R2: An address byte that does not match, or that has its LSB at 1, gets no acknowledge. Every later byte gets no acknowledge either, until the next START. A STOP after such a transaction leaves `dac0_o`, `dac1_o` and `pwrdn_o` unchanged.
- R3: `sda_pull_o` is high only during the 9th SCL pulse of an accepted byte. It rises while SCL is low and falls when SCL falls, or at START or STOP. It is low while the eight bits of any byte are clocked.
- R4: Command byte fields are: bit 4 = clear, bit 3 = power-down, bit 0 = channel select (0 selects channel 0). Bits 7..5, 2 and 1 have no effect.
- R5: A data byte goes into the input latch of the channel picked by the preceding command. The outputs do not change before STOP.
- R6: At a STOP that ends an addressed transaction with at least one command byte, both output latches load from their input latches in the same clock cycle. Outputs change at no other time.
- R7: `pwrdn_o` takes the power-down bit of the last command byte at STOP, and stays unchanged before STOP. A data byte that follows a command with power-down set is still written and is committed at the same STOP.
- R8: If the last command byte has clear set, STOP zeroes both input and output latches. This overrides any data byte in the same transaction.
- R9: A transaction whose last command byte has no data byte only acts through power-down and clear. With clear at 0, the output codes stay as they were.
- R10: A repeated START restarts address matching and the bit count. Writes accepted before it stay pending and commit at the final STOP, even if the new address does not match.
- R11: After reset, `dac0_o`, `dac1_o`, `pwrdn_o` and `sda_pull_o` are all 0.
- R12: After a data byte, the next byte is decoded as a new command byte. Several channel writes can share one transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND) |
| addr_pin_i | input | 4 | Address straps; [3:2] used only when USE_ADDR_PINS=1 |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| dac0_o | output | 8 | Channel 0 output latch |
| dac1_o | output | 8 | Channel 1 output latch |
| pwrdn_o | output | 1 | Power-down state |

## Verification
The embedded properties check four things on every cycle: the output codes and the power-down flag change only in the cycle after a detected STOP, a clear commit leaves every latch at zero, and the acknowledge pull starts and ends only while SCL is low or at a bus condition. Other behaviours can only be shown by the bench's transactions. These are address matching against the straps, silence after a rejected or read address, routing of data by the select bit, the override of a data byte by clear, and carrying writes across a repeated START. The same holds for checking that both channels change in one cycle and that reserved command bits do nothing.

// File: rtl/ddac_pkg.sv
package ddac_pkg;
    localparam int DAC_W   = 8;
    localparam int N_CH    = 2;
    localparam int ADDR_W  = 7;
    localparam int CNT_W   = 4;
    localparam int BIT_RST = 4;
    localparam int BIT_PD  = 3;
    localparam int BIT_SEL = 0;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ADDR = 2'd1,
        RX_CMD  = 2'd2,
        RX_DATA = 2'd3
    } rx_phase_e;

    typedef struct packed {
        logic clr;
        logic pd;
        logic sel;
    } ddac_cmd_t;

    typedef struct packed {
        rx_phase_e        phase;
        logic [DAC_W-1:0] shreg;
        logic [CNT_W-1:0] nbits;
        logic             arm;
        logic             ack;
        logic             sel;
    } rx_state_t;

    typedef struct packed {
        logic [N_CH-1:0][DAC_W-1:0] inl;
        logic [N_CH-1:0][DAC_W-1:0] outl;
        logic                       pwrdn;
        logic                       pend;
        logic                       p_clr;
        logic                       p_pd;
    } reg_state_t;
endpackage

// File: rtl/ddac_line_sync.sv
module ddac_line_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] sync_o,
    output logic [N_LINES-1:0] prev_o
);
    logic [STAGES:0][N_LINES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int k = 1; k <= STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/ddac_bus_rx.sv
module ddac_bus_rx
    import ddac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              scl_p_i,
    input  logic              sda_s_i,
    input  logic              sda_p_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              ack_o,
    output logic              cmd_v_o,
    output ddac_cmd_t         cmd_o,
    output logic              dat_v_o,
    output logic [DAC_W-1:0]  dat_o,
    output logic              dat_sel_o,
    output logic              stop_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DAC_W - 1);
    localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(DAC_W);
    localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(DAC_W + 1);

    rx_state_t d, q;
    logic start_c, stop_c, rise_c, fall_c;
    logic [DAC_W-1:0] byte_w;

    assign start_c = scl_s_i & scl_p_i & sda_p_i & ~sda_s_i;
    assign stop_c  = scl_s_i & scl_p_i & ~sda_p_i & sda_s_i;
    assign rise_c  = scl_s_i & ~scl_p_i;
    assign fall_c  = ~scl_s_i & scl_p_i;
    assign byte_w  = {q.shreg[DAC_W-2:0], sda_s_i};

    always_comb begin
        d       = q;
        cmd_v_o = 1'b0;
        dat_v_o = 1'b0;
        if (start_c) begin
            d.phase = RX_ADDR;
            d.nbits = '0;
            d.arm   = 1'b0;
            d.ack   = 1'b0;
        end else if (stop_c) begin
            d.phase = RX_IDLE;
            d.nbits = '0;
            d.arm   = 1'b0;
            d.ack   = 1'b0;
        end else if (q.phase != RX_IDLE) begin
            if (rise_c && q.nbits < ACK_WAIT) begin
                d.shreg = byte_w;
                d.nbits = q.nbits + 1'b1;
                if (q.nbits == LAST_BIT) begin
                    d.arm = 1'b1;
                    unique case (q.phase)
                        RX_ADDR: begin
                            if (byte_w[DAC_W-1:1] == own_addr_i && !byte_w[0]) begin
                                d.phase = RX_CMD;
                            end else begin
                                d.phase = RX_IDLE;
                                d.arm   = 1'b0;
                            end
                        end
                        RX_CMD: begin
                            cmd_v_o = 1'b1;
                            d.sel   = byte_w[BIT_SEL];
                            d.phase = RX_DATA;
                        end
                        default: begin
                            dat_v_o = 1'b1;
                            d.phase = RX_CMD;
                        end
                    endcase
                end
            end else if (rise_c && q.nbits == ACK_WAIT) begin
                d.nbits = ACK_HIGH;
            end else if (fall_c && q.nbits == ACK_WAIT) begin
                d.ack = q.arm;
            end else if (fall_c && q.nbits == ACK_HIGH) begin
                d.ack   = 1'b0;
                d.arm   = 1'b0;
                d.nbits = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_o     = q.ack;
    assign cmd_o     = '{clr: byte_w[BIT_RST], pd: byte_w[BIT_PD], sel: byte_w[BIT_SEL]};
    assign dat_o     = byte_w;
    assign dat_sel_o = q.sel;
    assign stop_o    = stop_c;

    // R3: the pull may only begin while SCL is low
    p_ack_begin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> !scl_s_i);
    // R3: the pull ends on an SCL fall or a bus condition
    p_ack_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ack) |-> ($past(fall_c) || $past(start_c) || $past(stop_c)));
endmodule

// File: rtl/ddac_latch_bank.sv
module ddac_latch_bank
    import ddac_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_v_i,
    input  ddac_cmd_t                  cmd_i,
    input  logic                       dat_v_i,
    input  logic [DAC_W-1:0]           dat_i,
    input  logic                       dat_sel_i,
    input  logic                       stop_i,
    output logic [N_CH-1:0][DAC_W-1:0] code_o,
    output logic                       pwrdn_o
);
    reg_state_t d, q;

    always_comb begin
        d = q;
        if (cmd_v_i) begin
            d.pend  = 1'b1;
            d.p_clr = cmd_i.clr;
            d.p_pd  = cmd_i.pd;
        end
        if (dat_v_i) begin
            d.inl[dat_sel_i] = dat_i;
        end
        if (stop_i && q.pend) begin
            d.pend  = 1'b0;
            d.pwrdn = q.p_pd;
            if (q.p_clr) begin
                d.inl  = '0;
                d.outl = '0;
            end else begin
                d.outl = q.inl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code_o  = q.outl;
    assign pwrdn_o = q.pwrdn;

    // R6: codes move only right after a STOP
    p_hold_until_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |=> $stable(code_o));
    // R7: power-down changes only right after a STOP
    p_pd_at_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |=> $stable(pwrdn_o));
    // R8: a clear commit leaves every latch at zero
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && q.pend && q.p_clr) |=> (code_o == '0 && q.inl == '0));
endmodule

// File: rtl/dual_dac_i2c_slave.sv
module dual_dac_i2c_slave
    import ddac_pkg::*;
#(
    parameter bit USE_ADDR_PINS = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [3:0]       addr_pin_i,
    output logic             sda_pull_o,
    output logic [DAC_W-1:0] dac0_o,
    output logic [DAC_W-1:0] dac1_o,
    output logic             pwrdn_o
);
    logic [1:0] line_s, line_p;
    logic [1:0] addr_mid;
    logic [ADDR_W-1:0] own_addr;
    logic cmd_v, dat_v, dat_sel, stop_p;
    ddac_cmd_t cmd;
    logic [DAC_W-1:0] dat;
    logic [N_CH-1:0][DAC_W-1:0] codes;

    generate
        if (USE_ADDR_PINS) begin : g_pin_addr
            assign addr_mid = addr_pin_i[3:2];
        end else begin : g_fixed_addr
            logic unused_mid;
            assign unused_mid = ^addr_pin_i[3:2];
            assign addr_mid   = 2'b11;
        end
    endgenerate

    assign own_addr = {3'b010, addr_mid, addr_pin_i[1:0]};

    ddac_line_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (line_s),
        .prev_o (line_p)
    );

    ddac_bus_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (line_s[1]),
        .scl_p_i    (line_p[1]),
        .sda_s_i    (line_s[0]),
        .sda_p_i    (line_p[0]),
        .own_addr_i (own_addr),
        .ack_o      (sda_pull_o),
        .cmd_v_o    (cmd_v),
        .cmd_o      (cmd),
        .dat_v_o    (dat_v),
        .dat_o      (dat),
        .dat_sel_o  (dat_sel),
        .stop_o     (stop_p)
    );

    ddac_latch_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_v_i   (cmd_v),
        .cmd_i     (cmd),
        .dat_v_i   (dat_v),
        .dat_i     (dat),
        .dat_sel_i (dat_sel),
        .stop_i    (stop_p),
        .code_o    (codes),
        .pwrdn_o   (pwrdn_o)
    );

    assign dac0_o = codes[0];
    assign dac1_o = codes[1];
endmodule

// File: tb/tb_dual_dac_i2c_slave.sv
module tb_dual_dac_i2c_slave;
    localparam int Q = 6;
    localparam bit USE_PINS = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] pins = 4'b1001;
    logic sda_pull, pwrdn;
    logic [7:0] dac0, dac1;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_pull;
    always #4 clk = ~clk;

    dual_dac_i2c_slave #(.USE_ADDR_PINS(USE_PINS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_pin_i (pins),
        .sda_pull_o (sda_pull),
        .dac0_o     (dac0),
        .dac1_o     (dac1),
        .pwrdn_o    (pwrdn)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] m_in [2];
    logic [7:0] m_out [2];
    logic m_pd = 1'b0, m_pend = 1'b0, m_pclr = 1'b0, m_ppd = 1'b0, m_psel = 1'b0, m_ok = 1'b0;
    int at0, at1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] my_addr();
        return {3'b010, (USE_PINS ? pins[3:2] : 2'b11), pins[1:0]};
    endfunction

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic quiet);
        quiet = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl_m = 1'b1; qw();
            if (sda_pull) quiet = 1'b0;
            qw();
            scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        ack = sda_pull;
        qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input string req);
        logic ack, quiet;
        send_byte({a, rw}, ack, quiet);
        m_ok = (a == my_addr()) && !rw;
        chk(req, ack, m_ok);
        chk("R3 quiet during bits", quiet, 1'b1);
    endtask

    task automatic send_cmd(input logic [7:0] c, input string req);
        logic ack, quiet;
        send_byte(c, ack, quiet);
        chk(req, ack, m_ok);
        if (m_ok) begin
            m_pend = 1'b1;
            m_pclr = c[4];
            m_ppd  = c[3];
            m_psel = c[0];
        end
    endtask

    task automatic send_dat(input logic [7:0] v, input string req);
        logic ack, quiet;
        send_byte(v, ack, quiet);
        chk(req, ack, m_ok);
        if (m_ok) m_in[m_psel] = v;
    endtask

    task automatic bus_stop();
        logic [7:0] o0, o1;
        o0 = dac0;
        o1 = dac1;
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1;
        at0 = -1;
        at1 = -1;
        for (int i = 0; i < 3 * Q; i++) begin
            @(negedge clk);
            if (at0 < 0 && dac0 !== o0) at0 = i;
            if (at1 < 0 && dac1 !== o1) at1 = i;
        end
        if (m_pend) begin
            m_pd = m_ppd;
            if (m_pclr) begin
                m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
            end else begin
                m_out[0] = m_in[0]; m_out[1] = m_in[1];
            end
            m_pend = 1'b0;
        end
    endtask

    task automatic check_outs(input string req);
        chk({req, " dac0"}, dac0, m_out[0]);
        chk({req, " dac1"}, dac1, m_out[1]);
        chk({req, " pwrdn"}, pwrdn, m_pd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk("R11 pull", sda_pull, 1'b0);
        check_outs("R11");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R5 R6 R12: two channel writes in one transaction
        bus_start();
        send_addr(my_addr(), 1'b0, "R1 addr ack");
        send_cmd(8'h00, "R3 cmd ack");
        send_dat(8'hA5, "R3 data ack");
        chk("R5 ch0 held before stop", dac0, 8'h00);
        send_cmd(8'h01, "R12 second cmd ack");
        send_dat(8'h3C, "R12 second data ack");
        chk("R5 ch1 held before stop", dac1, 8'h00);
        bus_stop();
        check_outs("R6");
        chk("R6 same cycle", at0 == at1 && at0 >= 0, 1'b1);

        // R2 wrong address
        bus_start();
        send_addr(my_addr() ^ 7'h01, 1'b0, "R2 wrong addr no ack");
        send_cmd(8'h11, "R2 later byte no ack");
        send_dat(8'hFF, "R2 later byte no ack");
        bus_stop();
        check_outs("R2 unchanged");

        // R2 read bit set
        bus_start();
        send_addr(my_addr(), 1'b1, "R2 read no ack");
        send_cmd(8'h08, "R2 after read no ack");
        bus_stop();
        check_outs("R2 read unchanged");

        // R1 strap bits 3:2 take part in the match
        bus_start();
        send_addr(my_addr() ^ 7'h0C, 1'b0, "R1 mid bits mismatch");
        bus_stop();
        pins = 4'b0110;
        repeat (4) @(negedge clk);
        bus_start();
        send_addr(my_addr(), 1'b0, "R1 new straps ack");
        send_cmd(8'h01, "R1 cmd ack");
        send_dat(8'h77, "R1 data ack");
        bus_stop();
        check_outs("R1 write");

        // R7 power-down with data
        bus_start();
        send_addr(my_addr(), 1'b0, "R7 addr");
        send_cmd(8'h08, "R7 cmd");
        send_dat(8'h42, "R7 data");
        chk("R7 pd held before stop", pwrdn, 1'b0);
        bus_stop();
        check_outs("R7 pd and data at stop");

        // R4 R9 command only, reserved bits set, select 1
        bus_start();
        send_addr(my_addr(), 1'b0, "R9 addr");
        send_cmd(8'hE7, "R4 cmd ack");
        bus_stop();
        check_outs("R9 cmd only R4 reserved ignored");

        // R8 clear overrides data
        bus_start();
        send_addr(my_addr(), 1'b0, "R8 addr");
        send_cmd(8'h10, "R8 cmd");
        send_dat(8'h99, "R8 data");
        bus_stop();
        check_outs("R8 clear");
        bus_start();
        send_addr(my_addr(), 1'b0, "R8 addr2");
        send_cmd(8'h00, "R8 cmd2");
        bus_stop();
        check_outs("R8 inputs cleared");

        // R10 repeated START to self, then to a foreign address
        bus_start();
        send_addr(my_addr(), 1'b0, "R10 addr");
        send_cmd(8'h00, "R10 cmd");
        send_dat(8'h5A, "R10 data");
        bus_start();
        send_addr(my_addr(), 1'b0, "R10 readdress ack");
        send_cmd(8'h01, "R10 cmd2");
        send_dat(8'h6B, "R10 data2");
        chk("R10 held across restart", dac0, 8'h00);
        bus_stop();
        check_outs("R10 commit");
        bus_start();
        send_addr(my_addr(), 1'b0, "R10 addr3");
        send_cmd(8'h01, "R10 cmd3");
        send_dat(8'h12, "R10 data3");
        bus_start();
        send_addr(my_addr() ^ 7'h02, 1'b0, "R10 foreign no ack");
        bus_stop();
        check_outs("R10 pending survives foreign restart");

        // random mix: R4 R12 R2 R10
        for (int t = 0; t < 40; t++) begin
            int npairs;
            logic [6:0] a;
            logic rw;
            logic [7:0] c;
            a  = ($urandom % 8 == 0) ? my_addr() ^ 7'(1 + $urandom % 127) : my_addr();
            rw = ($urandom % 16 == 0);
            npairs = 1 + $urandom % 2;
            bus_start();
            send_addr(a, rw, "R1 R2 random addr");
            for (int p = 0; p < npairs; p++) begin
                c = 8'($urandom);
                if ($urandom % 8 != 0) c[4] = 1'b0;
                send_cmd(c, "R4 random cmd");
                if (p < npairs - 1 || $urandom % 4 != 0) begin
                    send_dat(8'($urandom), "R12 random data");
                end else begin
                    break;
                end
            end
            if ($urandom % 8 == 0) begin
                bus_start();
                send_addr(my_addr(), 1'b0, "R10 random restart");
            end
            bus_stop();
            check_outs("R12 random result");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule